// File: doc/BRIEF.md
# Memory-Mapped Event Timer

This block is a bus-attached timer built from one free-running up-counter and one compare channel. Software reaches it through a simple synchronous register port: an address, a write strobe, a 32-bit write word and a combinational read word. A global run bit starts and freezes the counter. While the counter is frozen, software may preload it. The channel compares its match value against the counter with modular equality. On a hit it records an event in a status bit and drives an interrupt line, provided the channel's interrupt enable is set.

The channel can signal in two styles. In level style the status bit latches until software acknowledges it. In edge style the status bit is a one-cycle pulse that software cannot touch. In periodic mode a period value is added to the match value on every hit, so events repeat. A one-shot flag in the channel configuration decides whether the next compare write reloads both the match value and the period, or the period alone.

A read-only register reports the counter clock period in femtoseconds, which is fixed by a parameter. A legacy-routing bit, a 5-bit routing number and two delivery-option bits are stored and read back but have no effect inside the block.

Top module: `evt_timer`

## Requirements
- R1: After reset the counter, global configuration, channel configuration, match value and status all read 0, and `irq` is low.
- R2: Global configuration at offset 0x10 keeps bits 1:0 (bit 0 run, bit 1 legacy routing). Channel configuration at 0x100 keeps bits 1, 2, 3, 6, 8, 13:9 and 14, so writing all ones reads back 0x0000_7F4E. All other bits read 0. Bits 8, 14 and 13:9 have no effect.
- R3: While the run bit is 0 the counter holds its value, and a write to offset 0xF0 loads it.
- R4: While the run bit is 1 the counter rises by exactly one per clock and wraps modulo 2^32. Writes to 0xF0 are ignored.
- R5: Offset 0x04 always reads the parameter PERIOD_FS (default 10,000,000) and ignores writes. Any offset other than 0x04, 0x10, 0x20, 0xF0, 0x100 and 0x108 reads 0.
- R6: Status bit 0 at offset 0x20 becomes 1 on the clock edge at which the running counter steps onto the match value, and not earlier. A match value behind the counter therefore fires only after the counter wraps.
- R7: In level style (channel configuration bit 1 = 1) the status bit stays 1 until software writes 0x20 with bit 0 = 1. A write with bit 0 = 0 leaves it set.
- R8: In edge style (channel configuration bit 1 = 0) the status bit is 1 for exactly one cycle per hit, and writes to 0x20 have no effect.
- R9: `irq` is high exactly when the status bit is 1 and channel configuration bit 2 is 1. The status bit still sets on a hit while bit 2 is 0.
- R10: In periodic mode (channel configuration bit 3 = 1), a write to 0x108 while bit 6 is 1 loads both the match value and the period and clears bit 6. A write while bit 6 is 0 loads only the period. Each hit adds the period to the match value.
- R11: In one-shot mode (bit 3 = 0) a write to 0x108 sets the match value, which reads back at 0x108 and does not change on a hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the register being accessed |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | Timer interrupt line |

## Verification
The checker watches every cycle for the following. The counter must hold while halted and step by one while running. A hit must always set the status bit. A latched level status must never drop without an acknowledge. An edge status must never outlive a halted cycle. `irq` must never be high without both status and enable. Exact event timing, register readback masks, unmapped reads, wrap-around matches and the periodic reload sequence can only be shown by the bench's scenarios. Those scenarios sweep the offset map, step through counter values one cycle at a time and compare each cycle against values computed from the requirements.

// File: rtl/evt_timer_pkg.sv
`timescale 1ns/1ps
package evt_timer_pkg;
   localparam int DATA_W = 32;

   // register byte offsets
   localparam logic [11:0] OFF_PERIOD = 12'h004;
   localparam logic [11:0] OFF_GCFG   = 12'h010;
   localparam logic [11:0] OFF_STAT   = 12'h020;
   localparam logic [11:0] OFF_CNT    = 12'h0F0;
   localparam logic [11:0] OFF_TCFG   = 12'h100;
   localparam logic [11:0] OFF_TCMP   = 12'h108;

   // global configuration bits
   localparam int GC_RUN    = 0;
   localparam int GC_LEGACY = 1;

   // channel configuration bits
   localparam int TC_LEVEL = 1;
   localparam int TC_IEN   = 2;
   localparam int TC_PER   = 3;
   localparam int TC_VSET  = 6;

   localparam logic [DATA_W-1:0] TCFG_KEEP = 32'h0000_7F4E;
   localparam logic [DATA_W-1:0] GCFG_KEEP = 32'h0000_0003;
endpackage

// File: rtl/evt_main_counter.sv
`timescale 1ns/1ps
module evt_main_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)    cnt_q <= '0;
      else if (load) cnt_q <= load_val;
      else if (run)  cnt_q <= cnt_q + CNT_W'(1);
   end
endmodule

// File: rtl/evt_channel.sv
`timescale 1ns/1ps
module evt_channel
   import evt_timer_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [CNT_W-1:0]  cnt_q,
   input  logic              cfg_wr,
   input  logic              cmp_wr,
   input  logic              stat_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] cfg_q,
   output logic [CNT_W-1:0]  cmp_q,
   output logic              status_q,
   output logic              irq
);
   logic [CNT_W-1:0] per_q;
   logic             hit;
   logic             level, periodic, vset;

   assign level    = cfg_q[TC_LEVEL];
   assign periodic = cfg_q[TC_PER];
   assign vset     = cfg_q[TC_VSET];
   assign hit      = tick && ((cnt_q + CNT_W'(1)) == cmp_q);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cfg_q <= '0;
      else if (cfg_wr)
         cfg_q <= wdata & TCFG_KEEP;
      else if (cmp_wr && periodic && vset)
         cfg_q[TC_VSET] <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_q <= '0;
         per_q <= '0;
      end else if (cmp_wr) begin
         if (!periodic)
            cmp_q <= wdata[CNT_W-1:0];
         else if (vset) begin
            cmp_q <= wdata[CNT_W-1:0];
            per_q <= wdata[CNT_W-1:0];
         end else
            per_q <= wdata[CNT_W-1:0];
      end else if (hit && periodic)
         cmp_q <= cmp_q + per_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         status_q <= 1'b0;
      else if (level)
         status_q <= hit | (status_q & ~(stat_wr & wdata[0]));
      else
         status_q <= hit;
   end

   assign irq = status_q & cfg_q[TC_IEN];
endmodule

// File: rtl/evt_timer.sv
`timescale 1ns/1ps
module evt_timer
   import evt_timer_pkg::*;
#(
   parameter int          ADDR_W    = 12,
   parameter int          CNT_W     = 32,
   parameter logic [31:0] PERIOD_FS = 32'd10_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq
);
   localparam logic [ADDR_W-1:0] A_PERIOD = ADDR_W'(OFF_PERIOD);
   localparam logic [ADDR_W-1:0] A_GCFG   = ADDR_W'(OFF_GCFG);
   localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFF_STAT);
   localparam logic [ADDR_W-1:0] A_CNT    = ADDR_W'(OFF_CNT);
   localparam logic [ADDR_W-1:0] A_TCFG   = ADDR_W'(OFF_TCFG);
   localparam logic [ADDR_W-1:0] A_TCMP   = ADDR_W'(OFF_TCMP);

   if (ADDR_W < 9) begin : g_bad_addr
      $error("evt_timer: ADDR_W must cover offset 0x108");
   end
   if (CNT_W < 8 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("evt_timer: CNT_W must be within 8..32");
   end

   logic [1:0]        gcfg_q;
   logic [CNT_W-1:0]  cnt_q, cmp_q;
   logic [DATA_W-1:0] tcfg_q, cnt_ext, cmp_ext;
   logic              status_q;
   logic              run, cnt_wr;

   assign run    = gcfg_q[GC_RUN];
   assign cnt_wr = bus_we && (bus_addr == A_CNT) && !run;

   always_ff @(posedge clk) begin
      if (!rst_n)
         gcfg_q <= '0;
      else if (bus_we && bus_addr == A_GCFG)
         gcfg_q <= bus_wdata[1:0];
   end

   evt_main_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .load     (cnt_wr),
      .load_val (bus_wdata[CNT_W-1:0]),
      .cnt_q    (cnt_q)
   );

   evt_channel #(.CNT_W(CNT_W)) u_ch0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (run),
      .cnt_q    (cnt_q),
      .cfg_wr   (bus_we && bus_addr == A_TCFG),
      .cmp_wr   (bus_we && bus_addr == A_TCMP),
      .stat_wr  (bus_we && bus_addr == A_STAT),
      .wdata    (bus_wdata),
      .cfg_q    (tcfg_q),
      .cmp_q    (cmp_q),
      .status_q (status_q),
      .irq      (irq)
   );

   if (CNT_W < DATA_W) begin : g_ext
      assign cnt_ext = {{(DATA_W-CNT_W){1'b0}}, cnt_q};
      assign cmp_ext = {{(DATA_W-CNT_W){1'b0}}, cmp_q};
   end else begin : g_full
      assign cnt_ext = cnt_q;
      assign cmp_ext = cmp_q;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_PERIOD)    bus_rdata = PERIOD_FS;
      else if (bus_addr == A_GCFG) bus_rdata = {30'd0, gcfg_q};
      else if (bus_addr == A_STAT) bus_rdata = {31'd0, status_q};
      else if (bus_addr == A_CNT)  bus_rdata = cnt_ext;
      else if (bus_addr == A_TCFG) bus_rdata = tcfg_q;
      else if (bus_addr == A_TCMP) bus_rdata = cmp_ext;
   end
endmodule

// File: rtl/evt_timer_chk.sv
`timescale 1ns/1ps
module evt_timer_chk
   import evt_timer_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int CNT_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [31:0]       bus_wdata,
   input logic              irq,
   input logic              run,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [CNT_W-1:0]  cmp_q,
   input logic              status_q,
   input logic              level,
   input logic              ien
);
   logic cnt_write, ack_write, cfg_write;
   assign cnt_write = bus_we && bus_addr == ADDR_W'(OFF_CNT);
   assign ack_write = bus_we && bus_addr == ADDR_W'(OFF_STAT) && bus_wdata[0];
   assign cfg_write = bus_we && bus_addr == ADDR_W'(OFF_TCFG);

   // R3
   frozen_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_write) |=> $stable(cnt_q));

   // R4
   step_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))));

   // R6
   match_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && (CNT_W'(cnt_q + CNT_W'(1)) == cmp_q)) |=> status_q);

   // R7
   level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (level && status_q && !ack_write && !cfg_write) |=> status_q);

   // R8
   edge_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!level && !run && !cfg_write) |=> !status_q);

   // R9
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ien && status_q));
endmodule

bind evt_timer evt_timer_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .irq       (irq),
   .run       (gcfg_q[0]),
   .cnt_q     (cnt_q),
   .cmp_q     (cmp_q),
   .status_q  (status_q),
   .level     (tcfg_q[1]),
   .ien       (tcfg_q[2])
);

// File: tb/evt_timer_bench.sv
`timescale 1ns/100ps
module evt_timer_bench;
   localparam logic [11:0] A_PER = 12'h004, A_GC = 12'h010, A_ST = 12'h020;
   localparam logic [11:0] A_CN = 12'h0F0, A_TC = 12'h100, A_CM = 12'h108;
   localparam logic [31:0] PFS = 32'd10_000_000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] addr = '0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   evt_timer u_evt_timer (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
      .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // called in the low clock phase; consumes one rising edge
   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      addr = a; we = 1'b1; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      addr = a; we = 1'b0;
      #0.3;
      d = rdata;
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, c0, c1;
      step(3);
      rst_n = 1'b1;

      // R1 reset state
      rd(A_CN, v); chk("R1 counter", v, 0);
      rd(A_GC, v); chk("R1 gcfg", v, 0);
      rd(A_ST, v); chk("R1 status", v, 0);
      rd(A_TC, v); chk("R1 tcfg", v, 0);
      step(1);
      rd(A_CM, v); chk("R1 match", v, 0);
      chk("R1 irq", {31'd0, irq}, 0);

      // R5 period register and unmapped offsets
      step(1);
      rd(A_PER, v); chk("R5 period", v, PFS);
      wr(A_PER, 32'h0);
      rd(A_PER, v); chk("R5 period write ignored", v, PFS);
      for (int a = 0; a < 'h110; a += 4) begin
         step(1);
         if (a != 'h04 && a != 'h10 && a != 'h20 && a != 'hF0 && a != 'h100 && a != 'h108) begin
            rd(12'(a), v); chk("R5 unmapped", v, 0);
         end
      end
      step(1);

      // R2 readback masks
      wr(A_TC, 32'hFFFF_FFFF);
      rd(A_TC, v); chk("R2 tcfg mask", v, 32'h0000_7F4E);
      wr(A_TC, 32'h0);
      wr(A_GC, 32'hFFFF_FFFE);
      rd(A_GC, v); chk("R2 gcfg mask", v, 32'h2);

      // R3 frozen counter and preload
      rd(A_CN, v); chk("R3 frozen", v, 0);
      wr(A_CN, 32'h1234);
      rd(A_CN, v); chk("R3 preload", v, 32'h1234);
      step(5);
      rd(A_CN, v); chk("R3 hold", v, 32'h1234);

      // R4 running counter
      wr(A_GC, 32'h3);
      rd(A_CN, c0); chk("R4 start value", c0, 32'h1234);
      step(7);
      rd(A_CN, c1); chk("R4 step per clock", c1, c0 + 7);
      step(1);
      rd(A_CN, c0);
      wr(A_CN, 32'h0);
      rd(A_CN, c1); chk("R4 write ignored while running", c1, c0 + 1);
      wr(A_GC, 32'h0);
      wr(A_CN, 32'hFFFF_FFFE);
      wr(A_GC, 32'h1);
      rd(A_CN, v); chk("R4 pre-wrap", v, 32'hFFFF_FFFE);
      step(3);
      rd(A_CN, v); chk("R4 wrap", v, 32'h1);
      wr(A_GC, 32'h0);

      // R6 R7 R9 R11 level one-shot match
      wr(A_CN, 32'h100);
      wr(A_TC, 32'h6);
      wr(A_CM, 32'h110);
      rd(A_CM, v); chk("R11 match readback", v, 32'h110);
      wr(A_GC, 32'h1);
      step(15);
      rd(A_CN, v); chk("R6 counter before", v, 32'h10F);
      rd(A_ST, v); chk("R6 no early status", v, 0);
      step(1);
      rd(A_CN, v); chk("R6 counter at match", v, 32'h110);
      rd(A_ST, v); chk("R6 status on match", v, 1);
      chk("R9 irq on match", {31'd0, irq}, 1);
      step(5);
      rd(A_ST, v); chk("R7 level holds", v, 1);
      rd(A_CM, v); chk("R11 match unchanged after hit", v, 32'h110);
      wr(A_ST, 32'h0);
      rd(A_ST, v); chk("R7 zero write keeps", v, 1);
      wr(A_ST, 32'h1);
      rd(A_ST, v); chk("R7 ack clears", v, 0);
      chk("R7 irq drops", {31'd0, irq}, 0);
      wr(A_GC, 32'h0);

      // R8 edge style pulse
      wr(A_CN, 32'h0);
      wr(A_TC, 32'h4);
      wr(A_CM, 32'h20);
      wr(A_ST, 32'h1);
      rd(A_ST, v); chk("R8 status write no effect", v, 0);
      wr(A_GC, 32'h1);
      step(31);
      chk("R8 irq before", {31'd0, irq}, 0);
      step(1);
      rd(A_CN, v); chk("R8 counter at match", v, 32'h20);
      rd(A_ST, v); chk("R8 pulse high", v, 1);
      chk("R8 irq pulse", {31'd0, irq}, 1);
      step(1);
      rd(A_ST, v); chk("R8 pulse one cycle", v, 0);
      chk("R8 irq ends", {31'd0, irq}, 0);
      wr(A_GC, 32'h0);

      // R9 enable gating
      wr(A_CN, 32'h0);
      wr(A_TC, 32'h2);
      wr(A_CM, 32'h8);
      wr(A_GC, 32'h1);
      step(12);
      rd(A_ST, v); chk("R9 status with irq disabled", v, 1);
      chk("R9 irq masked", {31'd0, irq}, 0);
      wr(A_TC, 32'h6);
      chk("R9 irq after enable", {31'd0, irq}, 1);
      wr(A_GC, 32'h0);
      wr(A_ST, 32'h1);

      // R6 match value behind counter
      wr(A_CN, 32'hFFFF_FFF8);
      wr(A_CM, 32'h4);
      wr(A_GC, 32'h1);
      step(8);
      rd(A_CN, v); chk("R6 wrapped", v, 0);
      chk("R6 no fire before wrap", {31'd0, irq}, 0);
      step(3);
      chk("R6 no fire at 3", {31'd0, irq}, 0);
      step(1);
      rd(A_CN, v); chk("R6 counter 4", v, 32'h4);
      chk("R6 fire after wrap", {31'd0, irq}, 1);
      wr(A_GC, 32'h0);
      wr(A_ST, 32'h1);

      // R10 periodic reload
      wr(A_CN, 32'h0);
      wr(A_TC, 32'h4C);
      wr(A_CM, 32'd10);
      rd(A_TC, v); chk("R10 value-set cleared", v, 32'h0C);
      rd(A_CM, v); chk("R10 match loaded", v, 32'd10);
      wr(A_CM, 32'd7);
      rd(A_CM, v); chk("R10 period-only write", v, 32'd10);
      wr(A_GC, 32'h1);
      for (int i = 0; i < 30; i++) begin
         step(1);
         rd(A_CN, c0);
         chk("R10 periodic events", {31'd0, irq},
             {31'd0, (c0 == 10 || c0 == 17 || c0 == 24)});
      end
      rd(A_CM, v); chk("R10 next match", v, 32'd31);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule